// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This combinational unit adds or subtracts two operands and returns the sum or difference together with six status flags. Each operation chooses an active width of 8, 16 or 32 bits. Bits of the operands above the active width are ignored. Bits of the result above it are driven to zero. All six flags are derived from that same active width. A datapath uses the block as the arithmetic half of its integer unit, and a separate register outside the block captures the flags it produces.

On subtraction the carry flag reports a borrow out of the top bit of the active width. The auxiliary flag likewise reports a borrow across its boundary. The carry and overflow conditions are computed separately. This lets unsigned and signed comparisons built on the result each read their own condition.

Top module: `asf_unit`

## Requirements
- R1: `result` equals (A + B) or (A - B) modulo 2^w, where w is the active width. All bits of `result` at or above w are 0.
- R2: `flags[0]` (carry) is 1 when an addition carries out of bit w-1, or when a subtraction borrows into bit w-1 (unsigned A < B). Otherwise it is 0.
- R3: `flags[1]` (parity) is 1 when the count of one bits in the w-bit result is even, and 0 when that count is odd.
- R4: For the 8-bit and 32-bit widths, `flags[2]` (auxiliary) is 1 when there is a carry or borrow across the boundary between bit 3 and bit 4.
- R5: For the 16-bit width, `flags[2]` (auxiliary) is 1 when there is a carry or borrow across the boundary between bit 7 and bit 8.
- R6: `flags[3]` (zero) is 1 exactly when the w-bit result is all zeros.
- R7: `flags[4]` (sign) equals bit w-1 of the result.
- R8: `flags[5]` (overflow) is 1 when the two's-complement result of the signed operation does not fit in w bits. It is independent of the carry flag.
- R9: Operand bits at or above the active width have no effect on `result` or `flags`.
- R10: `width_sel` encodes 2'b00 as 8 bits, 2'b01 as 16 bits, 2'b10 as 32 bits, and 2'b11 also as 32 bits. `sub_sel` = 0 adds and `sub_sel` = 1 subtracts B from A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | DATA_W | First operand (minuend on subtraction) |
| op_b | input | DATA_W | Second operand (subtrahend on subtraction) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| width_sel | input | 2 | Active width code (see R10) |
| result | output | DATA_W | Sum or difference, zero above the active width |
| flags | output | 6 | {overflow, sign, zero, auxiliary, parity, carry}, overflow in bit 5 |

## Verification
The hardest cases at the wider widths are those where carry, overflow and auxiliary carry must be told apart at the same time. An example is a 32-bit subtraction that borrows out of the top bit while the signed result still fits. Random 32-bit operands reach such cases only rarely. The stimulus therefore places operands near the signed and unsigned limits of each width, in addition to the random sweeps. The 8-bit width is swept over every operand pair in both directions, so every flag combination at that width occurs. Garbage is placed in operand bits above the active width to show that it changes nothing.

// File: rtl/asf_pkg.sv
package asf_pkg;

   typedef enum logic [1:0] {
      ASF_W8   = 2'b00,
      ASF_W16  = 2'b01,
      ASF_W32  = 2'b10,
      ASF_W32B = 2'b11
   } asf_width_e;

   localparam int ASF_FLAG_N = 6;
   localparam int ASF_CF     = 0;
   localparam int ASF_PF     = 1;
   localparam int ASF_AF     = 2;
   localparam int ASF_ZF     = 3;
   localparam int ASF_SF     = 4;
   localparam int ASF_OF     = 5;

   localparam int ASF_NIB_EDGE  = 4;
   localparam int ASF_BYTE_EDGE = 8;

   function automatic int asf_bits(input asf_width_e wc);
      case (wc)
         ASF_W8:  return 8;
         ASF_W16: return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int asf_aux_edge(input asf_width_e wc);
      return (wc == ASF_W16) ? ASF_BYTE_EDGE : ASF_NIB_EDGE;
   endfunction

endpackage

// File: rtl/asf_lane_mask.sv
module asf_lane_mask
   import asf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  asf_width_e          wc,
   output logic [DATA_W-1:0]   mask
);
   localparam int LANES = DATA_W / 8;

   int active_lanes;
   always_comb begin
      active_lanes = asf_bits(wc) / 8;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mask[g*8 +: 8] = (g < active_lanes) ? 8'hFF : 8'h00;
   end
endmodule

// File: rtl/asf_carry_chain.sv
module asf_carry_chain #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [DATA_W-1:0] mask,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W:0]   carries
);
   localparam int EXT_W = DATA_W + 1;

   logic [DATA_W-1:0] a_m;
   logic [DATA_W-1:0] b_eff;
   logic [EXT_W-1:0]  raw;

   always_comb begin
      a_m     = a_in & mask;
      b_eff   = (sub ? ~b_in : b_in) & mask;
      raw     = {1'b0, a_m} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
      carries = {1'b0, a_m} ^ {1'b0, b_eff} ^ raw;
      sum     = raw[DATA_W-1:0] & mask;
   end
endmodule

// File: rtl/asf_flag_gen.sv
module asf_flag_gen
   import asf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]     sum,
   input  logic [DATA_W:0]       carries,
   input  logic                  sub,
   input  asf_width_e            wc,
   output logic [ASF_FLAG_N-1:0] flags
);
   int   w;
   int   edge_bit;
   logic c_out;
   logic c_msb;

   always_comb begin
      w        = asf_bits(wc);
      edge_bit = asf_aux_edge(wc);
      c_out    = carries[w];
      c_msb    = carries[w-1];
      flags          = '0;
      flags[ASF_CF]  = c_out ^ sub;
      flags[ASF_PF]  = ~(^sum);
      flags[ASF_AF]  = carries[edge_bit] ^ sub;
      flags[ASF_ZF]  = (sum == '0);
      flags[ASF_SF]  = sum[w-1];
      flags[ASF_OF]  = c_out ^ c_msb;
   end
endmodule

// File: rtl/asf_unit.sv
module asf_unit
   import asf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              sub_sel,
   input  logic [1:0]        width_sel,
   output logic [DATA_W-1:0] result,
   output logic [5:0]        flags
);
   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("asf_unit: DATA_W must be a multiple of 8 and at least 32");
   end

   asf_width_e        wc;
   logic [DATA_W-1:0] mask;
   logic [DATA_W:0]   carries;

   assign wc = asf_width_e'(width_sel);

   asf_lane_mask #(.DATA_W(DATA_W)) u_mask (
      .wc   (wc),
      .mask (mask)
   );

   asf_carry_chain #(.DATA_W(DATA_W)) u_chain (
      .a_in    (op_a),
      .b_in    (op_b),
      .mask    (mask),
      .sub     (sub_sel),
      .sum     (result),
      .carries (carries)
   );

   asf_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .sum     (result),
      .carries (carries),
      .sub     (sub_sel),
      .wc      (wc),
      .flags   (flags)
   );

   logic sign_a;
   logic top_bit;
   logic upper_clear;
   always_comb begin
      case (wc)
         ASF_W8:  begin sign_a = op_a[7];  top_bit = result[7];  upper_clear = (result[DATA_W-1:8]  == '0); end
         ASF_W16: begin sign_a = op_a[15]; top_bit = result[15]; upper_clear = (result[DATA_W-1:16] == '0); end
         default: begin sign_a = op_a[31]; top_bit = result[31]; upper_clear = (DATA_W == 32) ? 1'b1
                                                                               : ((result >> 32) == '0); end
      endcase
      p_upper_zero_r1: assert (upper_clear);
      p_sign_msb_r7: assert (flags[ASF_SF] == top_bit);
      p_zero_result_r6: assert (flags[ASF_ZF] == (result == '0));
      if (sub_sel && ((op_a & mask) == (op_b & mask))) begin
         p_equal_sub_r2: assert (!flags[ASF_CF] && flags[ASF_ZF]);
      end
      if (flags[ASF_OF]) begin
         p_ovf_flips_sign_r8: assert (top_bit != sign_a);
      end
   end
endmodule

// File: tb/test_asf_unit.sv
module test_asf_unit;
   localparam int DATA_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [DATA_W-1:0] op_a, op_b, result;
   logic              sub_sel;
   logic [1:0]        width_sel;
   logic [5:0]        flags;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   asf_unit #(.DATA_W(DATA_W)) i_asf_unit (
      .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel), .width_sel(width_sel),
      .result(result), .flags(flags)
   );

   task automatic model(input logic [31:0] a, input logic [31:0] b, input bit sub,
                        input logic [1:0] wc, output logic [31:0] r, output logic [5:0] f);
      int w, k;
      longint unsigned m, km, ua, ub, full, lim;
      longint sa, sb, sr, hi, lo;
      bit cf, af, of;
      w  = (wc == 2'b00) ? 8 : (wc == 2'b01) ? 16 : 32;
      k  = (w == 16) ? 8 : 4;
      m  = (64'd1 << w) - 1;
      km = (64'd1 << k) - 1;
      ua = {32'd0, a} & m;
      ub = {32'd0, b} & m;
      if (sub) begin
         full = (ua - ub) & m;
         cf   = ua < ub;
         af   = (ua & km) < (ub & km);
      end else begin
         full = ua + ub;
         cf   = ((full >> w) & 1) != 0;
         af   = ((((ua & km) + (ub & km)) >> k) & 1) != 0;
      end
      r   = 32'(full & m);
      lim = 64'd1 << (w - 1);
      sa  = (ua >= lim) ? longint'(ua) - longint'(lim << 1) : longint'(ua);
      sb  = (ub >= lim) ? longint'(ub) - longint'(lim << 1) : longint'(ub);
      sr  = sub ? sa - sb : sa + sb;
      hi  = longint'(lim) - 1;
      lo  = -longint'(lim);
      of  = (sr > hi) || (sr < lo);
      f   = {of, r[w-1], (r == 32'd0), af, ($countones(r) % 2 == 0), cf};
   endtask

   task automatic run(input logic [31:0] a, input logic [31:0] b, input bit sub,
                      input logic [1:0] wc, input string tag);
      logic [31:0] er;
      logic [5:0]  ef;
      op_a = a; op_b = b; sub_sel = sub; width_sel = wc;
      #1;
      model(a, b, sub, wc, er, ef);
      checks++;
      if (result !== er || flags !== ef) begin
         errors++;
         $display("FAIL %s: a=%h b=%h sub=%0d w=%0d result=%h flags=%b expected result=%h flags=%b",
                  tag, a, b, sub, wc, result, flags, er, ef);
      end
   endtask

   task automatic expect_flags(input logic [5:0] exp, input string tag);
      checks++;
      if (flags !== exp) begin
         errors++;
         $display("FAIL %s: flags=%b expected %b", tag, flags, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
   end

   initial begin
      wait (cycles == 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      op_a = '0; op_b = '0; sub_sel = 1'b0; width_sel = 2'b00;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Idle inputs: 0+0 gives zero and even parity (R6, R3)
      run(32'h0, 32'h0, 1'b0, 2'b00, "R6 R3 idle");
      // Corner cases with hand-derived flags {OF,SF,ZF,AF,PF,CF}
      run(32'h7F, 32'h1, 1'b0, 2'b00, "R8 7F+1");
      expect_flags(6'b110100, "R8 R4 7F+1 flags");
      run(32'h80, 32'h1, 1'b1, 2'b00, "R8 80-1");
      expect_flags(6'b100100, "R8 R4 80-1 flags");
      run(32'h0, 32'h1, 1'b1, 2'b00, "R2 0-1");
      expect_flags(6'b010111, "R2 R7 0-1 flags");
      run(32'hFF, 32'h1, 1'b0, 2'b00, "R2 R6 FF+1");
      expect_flags(6'b001111, "R2 R6 FF+1 flags");
      run(32'h00FF, 32'h0001, 1'b0, 2'b01, "R5 word edge");
      expect_flags(6'b000100, "R5 word aux at bit 8");
      run(32'h000F, 32'h0001, 1'b0, 2'b01, "R5 no nibble aux");
      expect_flags(6'b000000, "R5 nibble carry ignored in word");
      run(32'h0000000F, 32'h1, 1'b0, 2'b10, "R4 dword nibble");
      expect_flags(6'b000100, "R4 dword aux at bit 4");
      run(32'h80000000, 32'h80000000, 1'b0, 2'b11, "R10 R8 code 3");
      expect_flags(6'b101011, "R10 R8 R2 dword wrap");
      run(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 2'b10, "R8 R2 both set");
      run(32'h12345678, 32'h12345678, 1'b1, 2'b10, "R6 R1 dword equal");
      // Upper operand bits must be ignored (R9)
      run(32'hABCDEF7F, 32'h12345601, 1'b0, 2'b00, "R9 byte garbage");
      checks++;
      if (result !== 32'h80) begin errors++; $display("FAIL R9: result=%h expected %h", result, 32'h80); end
      run(32'hFFFF8000, 32'hAAAA0001, 1'b1, 2'b01, "R9 R1 word garbage");
      checks++;
      if (result !== 32'h7FFF) begin errors++; $display("FAIL R9: result=%h expected %h", result, 32'h7FFF); end
      // Exhaustive byte sweep both directions (R1 R2 R3 R4 R6 R7 R8)
      for (int s = 0; s < 2; s++)
         for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
               run(32'(x) | (32'($urandom) << 8), 32'(y), s[0], 2'b00, "R1 R2 R3 R4 R6 R7 R8 byte sweep");
      // Random word and dword, plus limit-adjacent values (R5 R8 R10)
      for (int i = 0; i < 1500; i++) begin
         run($urandom, $urandom, i[0], 2'b01, "R5 R1 R3 word random");
         run($urandom, $urandom, i[1], 2'b10, "R4 R2 R8 dword random");
         run(32'h7FFFFFF0 + $urandom_range(0, 31), $urandom_range(0, 31), i[2], {1'b1, i[3]},
             "R8 R10 dword limits");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule